// File: doc/BRIEF.md
# Interrupt Priority Resolution Unit

This block holds three 256-bit vector arrays: pending requests, in-service vectors and the trigger mode of each vector. It decides which pending vector, if any, may be handed to the processor core. A requester presents a vector with its trigger mode on the accept port. The block answers in the same cycle whether the request was newly latched or refused because the vector is reserved. The core reads the deliverable vector and takes it with an acknowledge pulse, which moves the vector from pending to in-service.

When the core finishes a handler it pulses end-of-interrupt. This retires the highest in-service vector. If that vector was level-triggered, the block emits a one-cycle broadcast carrying the vector, so the interrupt source can re-sample its line. A task-priority register sets the masking threshold. It can be written as a full 8-bit value or through a 4-bit class view. The processor priority that gates delivery is computed without a register stage, from the task priority and the class of the highest in-service vector.

Each accept request is classified into one of six outcomes: ACC_IDLE (no request), ACC_OFF (block disabled), ACC_RESERVED (vector below 16), ACC_NEW (pending bit was clear), ACC_REPEAT_EDGE and ACC_REPEAT_LEVEL (pending bit already set). A `unique case` on the outcome drives the next-state update.

Top module: `ipr_unit`

## Requirements
- R1: After reset, the pending, in-service and trigger arrays are clear, the task priority is 0, `ppr` is 0, `deliver_valid` and `eoi_bcast` are 0, and `cr_view` is 0.
- R2: `deliver_vector` is the numerically highest vector whose pending bit is set, including across 32-bit word boundaries and at vector 255.
- R3: `ppr` is derived from the task priority T and the in-service value S, where S is the highest in-service vector or 0 if none. If T[7:4] >= S[7:4], `ppr` equals T. Otherwise `ppr` equals {S[7:4], 4'h0}. `ppr` follows any state change from the first cycle after the clock edge that makes it.
- R4: `deliver_valid` is 1 only when some pending bit is set and {vector[7:4], 4'h0} of the highest pending vector is strictly greater than the full 8-bit `ppr`.
- R5: `acc_ok` is 1, combinationally in the request cycle, only when the request is latched and the vector's pending bit was clear. A request for an already-pending vector returns 0.
- R6: A level request (`acc_level`=1) for an already-pending vector is dropped and leaves its trigger bit unchanged. An edge request for an already-pending vector keeps the pending bit set and clears the trigger bit. A new request sets the trigger bit to `acc_level`.
- R7: Unless both `hw_en` and `sw_en` are 1, accept requests change no state and `acc_ok` is 0, and `deliver_valid` is 0.
- R8: Requests for vectors 0 to 15 are refused: `acc_reserved` is 1, `acc_ok` is 0, and no state changes.
- R9: An `ack` while `deliver_valid` is 1 sets the in-service bit of `deliver_vector` and clears its pending bit. An `ack` while `deliver_valid` is 0 has no effect.
- R10: An `eoi` clears only the highest in-service bit. With nothing in service, `eoi` has no effect.
- R11: If the vector retired by `eoi` had its trigger bit set, the trigger bit is cleared, and `eoi_bcast` is 1 for exactly the cycle after the strobe with `eoi_bcast_vector` equal to that vector. An edge vector produces no broadcast.
- R12: `tpr_wr` loads the task priority from the 8-bit `tpr_data`. `cr_wr` loads it as {`cr_data`, 4'h0}, and `tpr_wr` wins if both are asserted. `cr_view` always shows task priority[7:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| acc_valid | input | 1 | Accept request strobe |
| acc_vector | input | 8 | Requested vector |
| acc_level | input | 1 | 1 = level trigger, 0 = edge |
| acc_ok | output | 1 | Request newly latched (same cycle) |
| acc_reserved | output | 1 | Request refused: reserved vector |
| ack | input | 1 | Core takes the deliverable vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Full task-priority write |
| tpr_data | input | 8 | Task-priority value |
| cr_wr | input | 1 | Class-view task-priority write |
| cr_data | input | 4 | Class value for the task priority |
| cr_view | output | 4 | Task priority[7:4] |
| ppr | output | 8 | Processor priority |
| deliver_valid | output | 1 | A vector may be delivered |
| deliver_vector | output | 8 | Highest pending vector |
| eoi_bcast | output | 1 | Level end-of-interrupt broadcast pulse |
| eoi_bcast_vector | output | 8 | Vector carried by the broadcast |

## Verification
`acc_ok` and `acc_reserved` are combinational from the request and the stored state, so the bench samples them after driving a request and before the next edge. Every array and task-priority update lands on the next edge. `ppr`, `deliver_valid` and `deliver_vector` have no further register after that edge, so the bench samples them one time unit after that edge. `eoi_bcast` is the only registered output: it is checked high right after the edge that takes the strobe and low one cycle later. The sweeps cover every task-priority value against every vector class, in both the pending and the in-service direction, and compare the results against the formulas of R3 and R4 evaluated in the bench.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
    // Outcome of one accept request, decided in priority order
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_OFF,
        ACC_RESERVED,
        ACC_NEW,
        ACC_REPEAT_EDGE,
        ACC_REPEAT_LEVEL
    } acc_res_e;
endpackage

// File: rtl/ipr_top_scan.sv
// Finds the highest set bit of a wide vector, word by word
module ipr_top_scan #(
    parameter int NBITS = 256,
    parameter int WORDW = 32,
    localparam int NWORD = NBITS / WORDW,
    localparam int WBW   = $clog2(WORDW),
    localparam int IW    = $clog2(NBITS)
) (
    input  logic [NBITS-1:0] bits,
    output logic             hit,
    output logic [IW-1:0]    top
);
    logic [NWORD-1:0] w_hit;
    logic [WBW-1:0]   w_msb [NWORD];

    for (genvar g = 0; g < NWORD; g++) begin : g_word
        logic [WORDW-1:0] slice;
        logic [WBW-1:0]   msb;
        assign slice = bits[g*WORDW +: WORDW];
        always_comb begin
            msb = '0;
            for (int b = 0; b < WORDW; b++)
                if (slice[b]) msb = WBW'(b);
        end
        assign w_hit[g] = |slice;
        assign w_msb[g] = msb;
    end

    // the highest non-zero word wins
    always_comb begin
        hit = |w_hit;
        top = '0;
        for (int w = 0; w < NWORD; w++)
            if (w_hit[w]) top = IW'(w * WORDW) | IW'(w_msb[w]);
    end
endmodule

// File: rtl/ipr_prio_calc.sv
// Processor priority from task priority and highest in-service vector
module ipr_prio_calc #(
    parameter int VW = 8,
    localparam int CW = VW / 2
) (
    input  logic [VW-1:0] tpr,
    input  logic          isr_hit,
    input  logic [VW-1:0] isr_top,
    output logic [VW-1:0] ppr
);
    logic [VW-1:0] isv;
    always_comb begin
        isv = isr_hit ? isr_top : '0;
        if (tpr[VW-1:CW] >= isv[VW-1:CW]) ppr = tpr;
        else                              ppr = {isv[VW-1:CW], {CW{1'b0}}};
    end
endmodule

// File: rtl/ipr_unit.sv
module ipr_unit
    import ipr_pkg::*;
#(
    parameter int NVEC  = 256,
    parameter int WORDW = 32,
    parameter int RSVD  = 16,
    localparam int VW   = $clog2(NVEC),
    localparam int CW   = VW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_en,
    input  logic          sw_en,
    input  logic          acc_valid,
    input  logic [VW-1:0] acc_vector,
    input  logic          acc_level,
    output logic          acc_ok,
    output logic          acc_reserved,
    input  logic          ack,
    input  logic          eoi,
    input  logic          tpr_wr,
    input  logic [VW-1:0] tpr_data,
    input  logic          cr_wr,
    input  logic [CW-1:0] cr_data,
    output logic [CW-1:0] cr_view,
    output logic [VW-1:0] ppr,
    output logic          deliver_valid,
    output logic [VW-1:0] deliver_vector,
    output logic          eoi_bcast,
    output logic [VW-1:0] eoi_bcast_vector
);
    logic [NVEC-1:0] irr_q, isr_q, tmr_q;
    logic [NVEC-1:0] irr_d, isr_d, tmr_d;
    logic [NVEC-1:0] ack_mask, eoi_mask;
    logic [VW-1:0]   tpr_q;
    logic            irr_hit, isr_hit;
    logic [VW-1:0]   irr_top, isr_top;
    logic            enabled, do_ack, do_eoi;
    acc_res_e        acc_res;

    ipr_top_scan #(.NBITS(NVEC), .WORDW(WORDW)) u_irr_scan (
        .bits(irr_q), .hit(irr_hit), .top(irr_top));
    ipr_top_scan #(.NBITS(NVEC), .WORDW(WORDW)) u_isr_scan (
        .bits(isr_q), .hit(isr_hit), .top(isr_top));
    ipr_prio_calc #(.VW(VW)) u_prio (
        .tpr(tpr_q), .isr_hit(isr_hit), .isr_top(isr_top), .ppr(ppr));

    assign enabled        = hw_en & sw_en;
    assign deliver_vector = irr_top;
    assign deliver_valid  = enabled & irr_hit &
                            ({irr_top[VW-1:CW], {CW{1'b0}}} > ppr);
    assign do_ack         = ack & deliver_valid;
    assign do_eoi         = eoi & isr_hit;
    assign ack_mask       = do_ack ? (NVEC'(1) << irr_top) : '0;
    assign eoi_mask       = do_eoi ? (NVEC'(1) << isr_top) : '0;
    assign cr_view        = tpr_q[VW-1:CW];

    // classify the accept request
    always_comb begin
        if (!acc_valid)                      acc_res = ACC_IDLE;
        else if (!enabled)                   acc_res = ACC_OFF;
        else if (acc_vector < VW'(RSVD))     acc_res = ACC_RESERVED;
        else if (!irr_q[acc_vector])         acc_res = ACC_NEW;
        else if (acc_level)                  acc_res = ACC_REPEAT_LEVEL;
        else                                 acc_res = ACC_REPEAT_EDGE;
    end

    assign acc_ok       = (acc_res == ACC_NEW);
    assign acc_reserved = (acc_res == ACC_RESERVED);

    // next state of the three arrays; accept applies after ack and eoi
    always_comb begin
        irr_d = irr_q & ~ack_mask;
        isr_d = (isr_q | ack_mask) & ~eoi_mask;
        tmr_d = tmr_q & ~eoi_mask;
        unique case (acc_res)
            ACC_NEW: begin
                irr_d[acc_vector] = 1'b1;
                tmr_d[acc_vector] = acc_level;
            end
            ACC_REPEAT_EDGE: begin
                irr_d[acc_vector] = 1'b1;
                tmr_d[acc_vector] = 1'b0;
            end
            ACC_REPEAT_LEVEL: ;
            ACC_IDLE, ACC_OFF, ACC_RESERVED: ;
            default: ;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
            tpr_q <= '0;
        end else begin
            irr_q <= irr_d;
            isr_q <= isr_d;
            tmr_q <= tmr_d;
            if (tpr_wr)     tpr_q <= tpr_data;
            else if (cr_wr) tpr_q <= {cr_data, {CW{1'b0}}};
        end
    end

    // output register process: level end-of-interrupt broadcast
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_bcast        <= 1'b0;
            eoi_bcast_vector <= '0;
        end else begin
            eoi_bcast        <= do_eoi & tmr_q[isr_top];
            eoi_bcast_vector <= (do_eoi & tmr_q[isr_top]) ? isr_top : '0;
        end
    end
endmodule

// File: rtl/ipr_checker.sv
module ipr_checker #(
    parameter int VW   = 8,
    parameter int RSVD = 16,
    localparam int CW  = VW / 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hw_en,
    input logic          sw_en,
    input logic          acc_valid,
    input logic [VW-1:0] acc_vector,
    input logic          acc_ok,
    input logic          acc_reserved,
    input logic          ack,
    input logic          eoi,
    input logic [CW-1:0] cr_view,
    input logic [VW-1:0] ppr,
    input logic          deliver_valid,
    input logic [VW-1:0] deliver_vector,
    input logic          eoi_bcast
);
    assert_ppr_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ppr[VW-1:CW] >= cr_view);

    assert_ack_raises_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && deliver_valid && !eoi) |=> ppr[VW-1:CW] >= $past(deliver_vector[VW-1:CW]));

    assert_no_repeat_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ok && !ack) |=>
            !(acc_valid && acc_ok && acc_vector == $past(acc_vector)));

    assert_ok_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |-> (hw_en && sw_en));

    assert_no_delivery_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_en && sw_en) |-> !deliver_valid);

    assert_reserved_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_reserved |-> !acc_ok);

    assert_reserved_never_delivered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_valid |-> deliver_vector >= VW'(RSVD));

    assert_bcast_follows_eoi_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> $past(eoi));
endmodule

bind ipr_unit ipr_checker #(.VW(VW), .RSVD(RSVD)) u_ipr_checker (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
    .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_ok(acc_ok),
    .acc_reserved(acc_reserved), .ack(ack), .eoi(eoi), .cr_view(cr_view),
    .ppr(ppr), .deliver_valid(deliver_valid), .deliver_vector(deliver_vector),
    .eoi_bcast(eoi_bcast));

// File: tb/tb_ipr_unit.sv
module tb_ipr_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b1, sw_en = 1'b1;
    logic       acc_valid = 1'b0, acc_level = 1'b0;
    logic [7:0] acc_vector = '0;
    logic       acc_ok, acc_reserved;
    logic       ack = 1'b0, eoi = 1'b0, tpr_wr = 1'b0, cr_wr = 1'b0;
    logic [7:0] tpr_data = '0;
    logic [3:0] cr_data = '0;
    logic [3:0] cr_view;
    logic [7:0] ppr, deliver_vector, eoi_bcast_vector;
    logic       deliver_valid, eoi_bcast;

    int nchk = 0, nfail = 0;
    logic ok_s, rsv_s;

    always #2 clk = ~clk;

    ipr_unit dut (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
        .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_level(acc_level),
        .acc_ok(acc_ok), .acc_reserved(acc_reserved), .ack(ack), .eoi(eoi),
        .tpr_wr(tpr_wr), .tpr_data(tpr_data), .cr_wr(cr_wr), .cr_data(cr_data),
        .cr_view(cr_view), .ppr(ppr), .deliver_valid(deliver_valid),
        .deliver_vector(deliver_vector), .eoi_bcast(eoi_bcast),
        .eoi_bcast_vector(eoi_bcast_vector));

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
    endtask

    task automatic accept(input logic [7:0] v, input logic lvl);
        acc_valid = 1'b1; acc_vector = v; acc_level = lvl; #1;
        ok_s = acc_ok; rsv_s = acc_reserved;
        step(); acc_valid = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1; step(); eoi = 1'b0;
    endtask

    task automatic write_tpr(input logic [7:0] d);
        tpr_wr = 1'b1; tpr_data = d; step(); tpr_wr = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        // R1: reset state, also after pending state existed
        step(); do_reset();
        chk("R1 ppr", ppr, 0);
        chk("R1 deliver_valid", deliver_valid, 0);
        chk("R1 eoi_bcast", eoi_bcast, 0);
        chk("R1 cr_view", cr_view, 0);
        accept(8'h40, 1'b0); pulse_ack(); accept(8'h90, 1'b0); write_tpr(8'h77);
        do_reset();
        chk("R1 arrays cleared", deliver_valid, 0);
        chk("R1 ppr after reuse", ppr, 0);

        // R2: highest pending vector
        accept(8'h25, 1'b0); accept(8'h9A, 1'b0); accept(8'h41, 1'b0); accept(8'h90, 1'b0);
        chk("R2 mixed", deliver_vector, 8'h9A);
        for (int k = 1; k < 8; k++) begin
            do_reset();
            accept(8'(32*k - 1), 1'b0); accept(8'(32*k), 1'b0); accept(8'h11, 1'b0);
            chk("R2 word boundary", deliver_vector, 32*k);
        end
        do_reset(); accept(8'hFF, 1'b0); accept(8'h12, 1'b0);
        chk("R2 top vector", deliver_vector, 255);

        // R4: every task priority against every pending class
        for (int c = 1; c < 16; c++) begin
            do_reset();
            accept(8'(c*16 + 3), 1'b0);
            for (int t = 0; t < 256; t++) begin
                write_tpr(8'(t));
                chk("R4 deliver gate", deliver_valid, (c*16 > t) ? 1 : 0);
            end
        end

        // R3: every task priority against every in-service class
        for (int c = 1; c < 16; c++) begin
            do_reset();
            accept(8'(c*16 + 5), 1'b0); pulse_ack();
            chk("R3 after ack", ppr, c*16);
            for (int t = 0; t < 256; t++) begin
                write_tpr(8'(t));
                chk("R3 ppr formula", ppr, ((t >> 4) >= c) ? t : c*16);
            end
        end

        // R5: success only on first request
        do_reset();
        accept(8'h50, 1'b0); chk("R5 first ok", ok_s, 1);
        accept(8'h50, 1'b0); chk("R5 repeat not ok", ok_s, 0);

        // R7: enable gating
        do_reset(); hw_en = 1'b0;
        accept(8'h44, 1'b0); chk("R7 hw off ok", ok_s, 0);
        hw_en = 1'b1; #1; chk("R7 hw off ignored", deliver_valid, 0);
        sw_en = 1'b0;
        accept(8'h44, 1'b0); chk("R7 sw off ok", ok_s, 0);
        sw_en = 1'b1; #1; chk("R7 sw off ignored", deliver_valid, 0);
        accept(8'h44, 1'b0); chk("R7 enabled ok", ok_s, 1);
        sw_en = 1'b0; #1; chk("R7 delivery masked", deliver_valid, 0);
        sw_en = 1'b1; #1; chk("R7 delivery restored", deliver_valid, 1);

        // R8: reserved vectors
        do_reset();
        accept(8'h0F, 1'b0);
        chk("R8 reserved flag", rsv_s, 1); chk("R8 reserved ok", ok_s, 0);
        chk("R8 no state", deliver_valid, 0);
        accept(8'h10, 1'b0);
        chk("R8 first legal flag", rsv_s, 0); chk("R8 first legal ok", ok_s, 1);
        chk("R8 first legal vector", deliver_vector, 16);

        // R9: ack moves vector; ack without delivery ignored
        do_reset();
        pulse_ack(); chk("R9 idle ack", ppr, 0);
        write_tpr(8'hF0); accept(8'h55, 1'b0);
        chk("R9 masked", deliver_valid, 0);
        pulse_ack(); write_tpr(8'h00);
        chk("R9 masked ack ignored", deliver_valid, 1);
        chk("R9 still pending", deliver_vector, 8'h55);
        pulse_ack();
        chk("R9 request cleared", deliver_valid, 0);
        chk("R9 in service", ppr, 8'h50);

        // R10: nested end-of-interrupt
        do_reset();
        accept(8'h30, 1'b0); pulse_ack(); accept(8'h80, 1'b0); pulse_ack();
        chk("R10 nested ppr", ppr, 8'h80);
        pulse_eoi(); chk("R10 top retired", ppr, 8'h30);
        pulse_eoi(); chk("R10 all retired", ppr, 0);
        pulse_eoi(); chk("R10 empty eoi ppr", ppr, 0);
        chk("R10 empty eoi bcast", eoi_bcast, 0);

        // R11: level broadcast timing, edge silent
        do_reset();
        accept(8'h66, 1'b1); pulse_ack(); pulse_eoi();
        chk("R11 bcast", eoi_bcast, 1); chk("R11 bcast vector", eoi_bcast_vector, 8'h66);
        step(); chk("R11 one cycle", eoi_bcast, 0);
        accept(8'h67, 1'b0); pulse_ack(); pulse_eoi();
        chk("R11 edge silent", eoi_bcast, 0);

        // R6: trigger bit on repeats
        do_reset();
        accept(8'h70, 1'b0); accept(8'h70, 1'b1); chk("R6 level repeat ok", ok_s, 0);
        pulse_ack(); pulse_eoi(); chk("R6 level repeat keeps edge", eoi_bcast, 0);
        accept(8'h71, 1'b1); accept(8'h71, 1'b0); chk("R6 edge repeat ok", ok_s, 0);
        chk("R6 edge repeat pending", deliver_vector, 8'h71);
        pulse_ack(); pulse_eoi(); chk("R6 edge repeat clears level", eoi_bcast, 0);
        accept(8'h72, 1'b1); accept(8'h72, 1'b1);
        pulse_ack(); pulse_eoi(); chk("R6 level kept", eoi_bcast, 1);

        // R12: task priority write ports
        do_reset();
        cr_wr = 1'b1; cr_data = 4'hA; step(); cr_wr = 1'b0;
        chk("R12 class view", cr_view, 10); chk("R12 class ppr", ppr, 8'hA0);
        write_tpr(8'hF7);
        chk("R12 full write", ppr, 8'hF7); chk("R12 view of full", cr_view, 15);
        tpr_wr = 1'b1; tpr_data = 8'h23; cr_wr = 1'b1; cr_data = 4'h9; step();
        tpr_wr = 1'b0; cr_wr = 1'b0;
        chk("R12 full write wins", ppr, 8'h23);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule